// File: doc/BRIEF.md
# Mode-Dependent Address/GPIO Port Controller

This block controls one 8-pin port that is reached through a small memory-mapped register bus. It has three registers: a direction register, a data register and a pull-up control register. A 3-bit operating-mode input decides what the pins are for. In the external-bus modes the pins carry the upper CPU address byte. In the mixed modes each pin is either an address line or a plain input. In single-chip mode the pins are general-purpose inputs and outputs.

For each pin the block produces an output enable, an output value and a pull-up enable. All three are registered. The block also takes in the sampled pin levels and the CPU address byte it may have to drive. The mode is expected to stay constant while the block is out of reset. The mode in force during reset selects the reset value of the direction register.

Top module: `addr_gpio_port`

## Requirements
- R1: Only the low 16 bits of `bus_addr` are decoded. The direction register is at 0xFFC1, the data register at 0xFFC3 and the pull-up register at 0xFFD8. A write with `bus_wr` high takes effect at the next rising clock edge. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R2: While `rst_n` is low, the direction register is 0xFF in modes 1 to 4 and 0x00 in every other mode. The data and pull-up registers are 0x00 in every mode.
- R3: The direction register cannot be read back: a read of 0xFFC1 always returns 0xFF.
- R4: In modes 1 to 4 every pin is enabled and drives the matching bit of `cpu_addr_hi`. Writes to the direction register have no effect in these modes.
- R5: In modes 5 and 6, a pin whose direction bit is 1 drives its `cpu_addr_hi` bit. A pin whose direction bit is 0 is an input with `pin_oe` low and `pin_out` low.
- R6: In mode 7, and in mode 0 (which behaves as mode 7), a pin whose direction bit is 1 drives its data-register bit. A pin whose direction bit is 0 is an input with `pin_out` low.
- R7: A read of 0xFFC3 returns the data-register bit for each output pin and the `pin_in` level for each input pin.
- R8: `pin_pu` bit i is 1 only when pull-up bit i is 1, pin i is an input, and the mode is not in 1 to 4. A pin that is being driven never has its pull-up enabled.
- R9: `pin_oe`, `pin_out` and `pin_pu` are registered. They reflect the register and `cpu_addr_hi` state one clock edge after that state changes, so a register write shows on the pins two edges after the write cycle.
- R10: The pull-up register reads back the last value written to it, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Operating mode |
| bus_addr | input | 24 | Register bus address (low 16 bits decoded) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cpu_addr_hi | input | 8 | Upper CPU address byte to drive |
| pin_in | input | 8 | Sampled pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
A wrong stored direction bit has two visible effects. It shows on `pin_oe` one edge after it is stored. It also changes which source a data-register read takes for that pin, and that change is immediate. A corrupt data or pull-up register shows on a read of its address in the same cycle, and on `pin_out` or `pin_pu` one edge later. A wrong mode decode shows right after reset: the enables are wrong, the pull-ups are wrong, or the pins drive address bits where data bits are expected. The bench samples exactly the edges R9 defines, so a result that arrives one cycle early or late counts as a miscompare.

// File: rtl/addr_gpio_port.sv
module addr_gpio_port #(
  parameter int          N         = 8,
  parameter int          AW        = 24,
  parameter int          DEC_W     = 16,
  parameter logic [15:0] DIR_ADDR  = 16'hFFC1,
  parameter logic [15:0] DATA_ADDR = 16'hFFC3,
  parameter logic [15:0] PULL_ADDR = 16'hFFD8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  cpu_addr_hi,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_oe,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_pu
);
  localparam logic [N-1:0] ALL1 = {N{1'b1}};
  localparam logic [N-1:0] ALL0 = {N{1'b0}};

  logic [N-1:0] dir_q, data_q, pull_q;
  logic [N-1:0] dir_eff, drive_val;
  logic [DEC_W-1:0] low_addr;
  logic bus_mode, mix_mode, io_mode;
  logic sel_dir, sel_data, sel_pull;

  assign bus_mode = (mode >= 3'd1) && (mode <= 3'd4);
  assign mix_mode = (mode == 3'd5) || (mode == 3'd6);
  assign io_mode  = !bus_mode && !mix_mode;

  assign low_addr = bus_addr[DEC_W-1:0];
  assign sel_dir  = low_addr == DIR_ADDR[DEC_W-1:0];
  assign sel_data = low_addr == DATA_ADDR[DEC_W-1:0];
  assign sel_pull = low_addr == PULL_ADDR[DEC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= bus_mode ? ALL1 : ALL0;
      data_q <= ALL0;
      pull_q <= ALL0;
    end else if (bus_wr) begin
      if (sel_dir && !bus_mode) dir_q <= bus_wdata;
      if (sel_data) data_q <= bus_wdata;
      if (sel_pull) pull_q <= bus_wdata;
    end
  end

  assign dir_eff   = bus_mode ? ALL1 : dir_q;
  assign drive_val = io_mode ? data_q : cpu_addr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_oe  <= bus_mode ? ALL1 : ALL0;
      pin_out <= ALL0;
      pin_pu  <= ALL0;
    end else begin
      pin_oe  <= dir_eff;
      pin_out <= dir_eff & drive_val;
      pin_pu  <= bus_mode ? ALL0 : (pull_q & ~dir_eff);
    end
  end

  always_comb begin
    if (sel_dir)       bus_rdata = ALL1;
    else if (sel_data) bus_rdata = (dir_eff & data_q) | (~dir_eff & pin_in);
    else if (sel_pull) bus_rdata = pull_q;
    else               bus_rdata = ALL0;
  end
endmodule

// File: rtl/addr_gpio_port_chk.sv
module addr_gpio_port_chk #(
  parameter int N  = 8,
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_rdata,
  input logic [N-1:0]  pin_oe,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  pin_pu
);
  logic in_bus;
  assign in_bus = (mode >= 3'd1) && (mode <= 3'd4);

  a_r4_bus_mode_all_drive: assert property (@(posedge clk) disable iff (!rst_n)
    in_bus |-> pin_oe == {N{1'b1}});

  a_r8_no_pull_on_driver: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);

  a_r8_no_pull_bus_mode: assert property (@(posedge clk) disable iff (!rst_n)
    in_bus |-> pin_pu == '0);

  a_r5_input_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  a_r3_dir_unreadable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:0] == 16'hFFC1) |-> bus_rdata == {N{1'b1}});
endmodule

bind addr_gpio_port addr_gpio_port_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
);

// File: tb/addr_gpio_port_bench.sv
`timescale 1ns/1ps
module addr_gpio_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd7;
  logic [23:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  cpu_addr_hi = '0;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_oe, pin_out, pin_pu;

  always #2.5 clk = ~clk;

  addr_gpio_port u_addr_gpio_port (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_addr_hi(cpu_addr_hi), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .pin_pu(pin_pu)
  );

  typedef struct { int kind; logic [7:0] exp; string req; } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam int K_OE = 0, K_OUT = 1, K_PU = 2, K_RD = 3;

  task automatic push(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  always begin
    @(negedge clk);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_OE:    act = pin_oe;
        K_OUT:   act = pin_out;
        K_PU:    act = pin_pu;
        default: act = bus_rdata;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic do_reset(logic [2:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [23:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    @(negedge clk);
    #2;
  endtask

  task automatic rd_chk(logic [23:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    push(K_RD, exp, req);
    drain();
  endtask

  initial begin
    // modes 1-4: bus mode
    do_reset(3'd3);
    cpu_addr_hi = 8'hA5;
    settle();
    push(K_OE, 8'hFF, "R2 bus-mode dir reset / R4");
    push(K_PU, 8'h00, "R2 pull reset");
    drain();
    settle();
    push(K_OUT, 8'hA5, "R4 drives cpu address");
    drain();
    rd_chk(24'h00FFC3, 8'h00, "R2 data reset");
    wr(24'h00FFC1, 8'h00);
    settle();
    push(K_OE, 8'hFF, "R4 dir write ignored");
    drain();
    rd_chk(24'h00FFC1, 8'hFF, "R3 dir read undefined");
    wr(24'h00FFD8, 8'hFF);
    settle();
    push(K_PU, 8'h00, "R8 no pull in bus mode");
    drain();
    rd_chk(24'h00FFD8, 8'hFF, "R10 pull readback");

    // modes 5/6
    do_reset(3'd5);
    cpu_addr_hi = 8'h3C;
    pin_in = 8'hAA;
    settle();
    push(K_OE, 8'h00, "R2 mixed-mode dir reset");
    push(K_OUT, 8'h00, "R5 inputs low");
    drain();
    wr(24'h00FFC1, 8'h0F);
    settle();
    push(K_OE, 8'h0F, "R5 dir enables");
    push(K_OUT, 8'h0C, "R5 address bits on outputs");
    drain();
    wr(24'h00FFC3, 8'h55);
    rd_chk(24'h00FFC3, 8'hA5, "R7 data read mix");
    wr(24'h00FFD8, 8'hFF);
    settle();
    push(K_PU, 8'hF0, "R8 pull on inputs only");
    drain();
    rd_chk(24'h00FFC1, 8'hFF, "R3 dir read in mode 5");

    // mode 7
    do_reset(3'd7);
    pin_in = 8'h3C;
    wr(24'h00FFC3, 8'h96);
    wr(24'h00FFC1, 8'hF0);
    settle();
    push(K_OE, 8'hF0, "R6 dir enables");
    push(K_OUT, 8'h90, "R6 data bits on outputs");
    drain();
    rd_chk(24'h00FFC3, 8'h9C, "R7 data read io");
    // R9: one edge after the write, register changed but pins not yet
    wr(24'h00FFC3, 8'hFF);
    push(K_OUT, 8'h90, "R9 pins lag register");
    #0.5;
    bus_addr = 24'h00FFC3;
    drain();
    settle();
    push(K_OUT, 8'hF0, "R9 pins updated next edge");
    drain();

    // mode 0 behaves as 7; decode checks
    do_reset(3'd0);
    settle();
    push(K_OE, 8'h00, "R2 mode 0 dir reset");
    drain();
    wr(24'h00FFC1, 8'hFF);
    wr(24'h00FFC3, 8'h5A);
    settle();
    push(K_OUT, 8'h5A, "R6 mode 0 as mode 7");
    drain();
    wr(24'h00FFC2, 8'h77);
    rd_chk(24'h00FFC3, 8'h5A, "R1 undecoded write no effect");
    rd_chk(24'h00FFC2, 8'h00, "R1 undecoded read zero");
    wr(24'hAB_FFC3, 8'h11);
    rd_chk(24'h00FFC3, 8'h11, "R1 upper address bits ignored");
    wr(24'h00FFD8, 8'h0F);
    rd_chk(24'h12FFD8, 8'h0F, "R10 pull readback mode 0");
    settle();
    push(K_PU, 8'h00, "R8 driven pins no pull");
    drain();

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule